// File: doc/BRIEF.md
# Per-Channel Resolution Calibration Controller

This controller periodically works out the smallest converter word length that each recording channel of a multi-channel neural front end can use without changing how spikes are classified. A programmable period timer opens a training window. Inside the window the controller walks the channels one at a time and points a single set of shared reduced-precision classifiers at the selected channel. For every detected spike it receives the class label taken from the full 8-bit sample, together with five labels taken from the same spike truncated to 3, 4, 5, 6 and 7 bits. It counts the spikes and, for each reduced width, the spikes whose label disagrees with the full-precision one.

When the dwell on a channel ends, the controller spends one cycle on evaluation. It tests every reduced width against a programmable error-rate limit NUM/DEN by cross-multiplying, so no divider is needed. It writes the lowest passing width into that channel's entry of a register bank and then moves to the next channel. While training is in progress, every channel reads as 8 bits, so full-precision data keeps flowing downstream. After the last channel has been written, a one-cycle done pulse marks the end of the window and the new widths take effect.

Top module: `res_cal_ctrl`

## Requirements
- R1: After reset every resolution field of `res_o` holds 8, `training_o` is 0 and `done_o` is 0.
- R2: A training window starts every `period_i` clock cycles. The first window begins after `period_i` rising edges following reset release, and `training_o` rises in that cycle.
- R3: While a channel is being collected, each cycle with `lbl_valid_i` high adds one spike. Reduced path k (slice `lbl_red_i[k*LBL_W +: LBL_W]`, holding the label at 3+k bits) adds one mismatch when its label differs from `lbl_ref_i`.
- R4: At evaluation the chosen width is 3+k for the lowest k with mismatch_k*`thr_den_i` < spikes*`thr_num_i`. The comparison is strict, so equality fails.
- R5: If no reduced width passes, or the channel saw zero spikes, the chosen width is 8.
- R6: Channels are visited in ascending order from 0 to N_CH-1, shown on `train_ch_o`. Each channel gets `window_i` collect cycles followed by one evaluation cycle, so channel c starts c*(`window_i`+1) cycles after the window opens.
- R7: While `training_o` is high, every field of `res_o` reads 8. The stored widths become visible once training ends. Field c occupies `res_o[c*RES_W +: RES_W]` and holds the width in bits as a binary number.
- R8: `done_o` pulses high for exactly one cycle, N_CH*(`window_i`+1) cycles after the window opens. `training_o` is already low in that cycle.
- R9: Counters are cleared at the start of every channel's collection. Labels presented outside a collect phase have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| period_i | input | TMR_W | Cycles between window starts |
| window_i | input | TMR_W | Collect cycles per channel |
| thr_num_i | input | THR_W | Error-rate limit numerator |
| thr_den_i | input | THR_W | Error-rate limit denominator |
| lbl_valid_i | input | 1 | A classified spike is presented |
| lbl_ref_i | input | LBL_W | Class label from the 8-bit sample |
| lbl_red_i | input | N_RED*LBL_W | Class labels from 3..7-bit samples, slice k is 3+k bits |
| train_ch_o | output | CH_W | Channel currently being trained |
| training_o | output | 1 | Training window active |
| done_o | output | 1 | One-cycle pulse when all channels are updated |
| res_o | output | N_CH*RES_W | Per-channel resolution in bits |

## Verification
A stale or miscounted tally shows up at the end of that channel's dwell as a wrong width in its `res_o` field, and the window is sized so that each channel's result separates neighbouring widths. A counter that is not cleared between windows is exposed by the second window, whose thresholds and patterns give different widths. A slipped dwell or channel counter moves the `train_ch_o` step times and the `done_o` cycle, and both are checked to the exact cycle. A wrongly gated output mux shows as a non-8 field in the middle of training.

// File: rtl/res_cal_pkg.sv
package res_cal_pkg;
  localparam int unsigned FULL_RES = 8;
  localparam int unsigned MIN_RES  = 3;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_EVAL    = 2'd2
  } cal_state_e;
endpackage

// File: rtl/cal_timer.sv
module cal_timer #(
  parameter int unsigned TMR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMR_W-1:0] period_i,
  output logic             tick_o
);
  logic [TMR_W-1:0] cnt_q;

  assign tick_o = (cnt_q + TMR_W'(1)) >= period_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + TMR_W'(1);
  end

  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && period_i > TMR_W'(1) && $stable(period_i)) |=> !tick_o);
endmodule

// File: rtl/cal_tally.sv
module cal_tally #(
  parameter int unsigned N_RED = 5,
  parameter int unsigned LBL_W = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   en_i,
  input  logic [LBL_W-1:0]       ref_i,
  input  logic [N_RED*LBL_W-1:0] red_i,
  output logic [CNT_W-1:0]       spk_o,
  output logic [N_RED*CNT_W-1:0] mis_o
);
  logic [CNT_W-1:0] spk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  spk_q <= '0;
    else if (clr_i)               spk_q <= '0;
    else if (en_i && spk_q != '1) spk_q <= spk_q + CNT_W'(1);
  end
  assign spk_o = spk_q;

  for (genvar k = 0; k < N_RED; k++) begin : g_path
    logic [CNT_W-1:0] mis_q;
    logic             diff;
    assign diff = red_i[k*LBL_W +: LBL_W] != ref_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mis_q <= '0;
      else if (clr_i)                       mis_q <= '0;
      else if (en_i && diff && mis_q != '1) mis_q <= mis_q + CNT_W'(1);
    end
    assign mis_o[k*CNT_W +: CNT_W] = mis_q;

    // a mismatch is only ever counted alongside its spike
    assert_mis_le_spk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mis_q <= spk_q);
  end
endmodule

// File: rtl/cal_pick.sv
module cal_pick #(
  parameter int unsigned N_RED = 5,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned THR_W = 8,
  parameter int unsigned RES_W = 4
) (
  input  logic [CNT_W-1:0]       spk_i,
  input  logic [N_RED*CNT_W-1:0] mis_i,
  input  logic [THR_W-1:0]       num_i,
  input  logic [THR_W-1:0]       den_i,
  output logic [RES_W-1:0]       res_o
);
  import res_cal_pkg::*;
  localparam int unsigned PW = CNT_W + THR_W;

  logic [N_RED-1:0] pass;
  logic [PW-1:0]    rhs;

  assign rhs = PW'(spk_i) * PW'(num_i);

  for (genvar k = 0; k < N_RED; k++) begin : g_cmp
    logic [PW-1:0] lhs;
    assign lhs     = PW'(mis_i[k*CNT_W +: CNT_W]) * PW'(den_i);
    assign pass[k] = (spk_i != '0) && (lhs < rhs);
  end

  // lowest passing width wins
  always_comb begin
    res_o = RES_W'(FULL_RES);
    for (int k = N_RED - 1; k >= 0; k--) begin
      if (pass[k]) res_o = RES_W'(MIN_RES + k);
    end
  end
endmodule

// File: rtl/cal_bank.sv
module cal_bank #(
  parameter int unsigned N_CH  = 96,
  parameter int unsigned RES_W = 4,
  parameter int unsigned CH_W  = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [CH_W-1:0]       addr_i,
  input  logic [RES_W-1:0]      din_i,
  output logic [N_CH*RES_W-1:0] q_o
);
  import res_cal_pkg::*;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [RES_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= RES_W'(FULL_RES);
      else if (we_i && addr_i == CH_W'(c))    q <= din_i;
    end
    assign q_o[c*RES_W +: RES_W] = q;
  end
endmodule

// File: rtl/res_cal_ctrl.sv
module res_cal_ctrl #(
  parameter int unsigned N_CH  = 96,
  parameter int unsigned N_RED = 5,
  parameter int unsigned LBL_W = 4,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned THR_W = 8,
  parameter int unsigned TMR_W = 32,
  parameter int unsigned RES_W = 4,
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [TMR_W-1:0]       period_i,
  input  logic [TMR_W-1:0]       window_i,
  input  logic [THR_W-1:0]       thr_num_i,
  input  logic [THR_W-1:0]       thr_den_i,
  input  logic                   lbl_valid_i,
  input  logic [LBL_W-1:0]       lbl_ref_i,
  input  logic [N_RED*LBL_W-1:0] lbl_red_i,
  output logic [CH_W-1:0]        train_ch_o,
  output logic                   training_o,
  output logic                   done_o,
  output logic [N_CH*RES_W-1:0]  res_o
);
  import res_cal_pkg::*;

  cal_state_e             state_q;
  logic [CH_W-1:0]        ch_q;
  logic [TMR_W-1:0]       dwell_q;
  logic                   done_q;
  logic                   tick, start, eval, clr;
  logic [CNT_W-1:0]       spk;
  logic [N_RED*CNT_W-1:0] mis;
  logic [RES_W-1:0]       pick_res;
  logic [N_CH*RES_W-1:0]  bank_q;

  assign start = (state_q == ST_IDLE) && tick;
  assign eval  = (state_q == ST_EVAL);
  assign clr   = start || eval;

  cal_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i, .rst_ni, .period_i, .tick_o(tick)
  );

  cal_tally #(.N_RED(N_RED), .LBL_W(LBL_W), .CNT_W(CNT_W)) u_tally (
    .clk_i, .rst_ni,
    .clr_i (clr),
    .en_i  (lbl_valid_i && state_q == ST_COLLECT),
    .ref_i (lbl_ref_i),
    .red_i (lbl_red_i),
    .spk_o (spk),
    .mis_o (mis)
  );

  cal_pick #(.N_RED(N_RED), .CNT_W(CNT_W), .THR_W(THR_W), .RES_W(RES_W)) u_pick (
    .spk_i (spk), .mis_i (mis), .num_i (thr_num_i), .den_i (thr_den_i), .res_o (pick_res)
  );

  cal_bank #(.N_CH(N_CH), .RES_W(RES_W), .CH_W(CH_W)) u_bank (
    .clk_i, .rst_ni, .we_i (eval), .addr_i (ch_q), .din_i (pick_res), .q_o (bank_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      dwell_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (tick) begin
          state_q <= ST_COLLECT;
          ch_q    <= '0;
          dwell_q <= '0;
        end
        ST_COLLECT: begin
          if ((dwell_q + TMR_W'(1)) >= window_i) state_q <= ST_EVAL;
          else                                   dwell_q <= dwell_q + TMR_W'(1);
        end
        ST_EVAL: begin
          dwell_q <= '0;
          if (ch_q == CH_W'(N_CH - 1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            ch_q    <= ch_q + CH_W'(1);
            state_q <= ST_COLLECT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign train_ch_o = ch_q;
  assign training_o = (state_q != ST_IDLE);
  assign done_o     = done_q;

  // full precision for every channel while the window is open
  for (genvar c = 0; c < N_CH; c++) begin : g_out
    assign res_o[c*RES_W +: RES_W] = training_o ? RES_W'(FULL_RES) : bank_q[c*RES_W +: RES_W];
  end

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !training_o);
  assert_zero_spk_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval && spk == '0) |-> pick_res == RES_W'(FULL_RES));
  assert_res_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval |-> (pick_res >= RES_W'(MIN_RES) && pick_res <= RES_W'(FULL_RES)));
  assert_ch_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval && ch_q != CH_W'(N_CH - 1)) |=> (ch_q == $past(ch_q) + CH_W'(1)));
  assert_ch_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_q <= CH_W'(N_CH - 1));
endmodule

// File: tb/res_cal_ctrl_tb.sv
`timescale 1ns/1ps
module res_cal_ctrl_tb;
  localparam int N_CH = 4, N_RED = 5, LBL_W = 4, CNT_W = 16, THR_W = 8;
  localparam int TMR_W = 32, RES_W = 4, CH_W = 2;
  localparam int P = 300, W = 40;

  logic clk_i = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic                   rst_ni;
  logic [TMR_W-1:0]       period_i, window_i;
  logic [THR_W-1:0]       thr_num_i, thr_den_i;
  logic                   lbl_valid_i;
  logic [LBL_W-1:0]       lbl_ref_i;
  logic [N_RED*LBL_W-1:0] lbl_red_i;
  logic [CH_W-1:0]        train_ch_o;
  logic                   training_o, done_o;
  logic [N_CH*RES_W-1:0]  res_o;

  res_cal_ctrl #(.N_CH(N_CH), .N_RED(N_RED), .LBL_W(LBL_W), .CNT_W(CNT_W),
                 .THR_W(THR_W), .TMR_W(TMR_W), .RES_W(RES_W)) u_dut (
    .clk_i, .rst_ni, .period_i, .window_i, .thr_num_i, .thr_den_i,
    .lbl_valid_i, .lbl_ref_i, .lbl_red_i, .train_ch_o, .training_o, .done_o, .res_o
  );

  int checks = 0, fails = 0, cyc = 0;
  int s [N_CH];
  int m [N_CH][N_RED];

  always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;

  always @(posedge clk_i) if (cyc > 3000) begin
    fails++;
    $display("FAIL watchdog: all requirements, act cyc=%0d exp <=3000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int calc(int c, int num, int den);
    for (int k = 0; k < N_RED; k++)
      if (s[c] > 0 && m[c][k] * den < s[c] * num) return 3 + k;
    return 8;
  endfunction

  task automatic noise(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      lbl_valid_i = 1'b1;
      lbl_ref_i   = '0;
      lbl_red_i   = '1;
    end
    @(negedge clk_i);
    lbl_valid_i = 1'b0;
  endtask

  task automatic drive_spikes(int c);
    logic [LBL_W-1:0] r;
    for (int i = 0; i < s[c]; i++) begin
      @(negedge clk_i);
      r = LBL_W'(i);
      lbl_valid_i = 1'b1;
      lbl_ref_i   = r;
      for (int k = 0; k < N_RED; k++)
        lbl_red_i[k*LBL_W +: LBL_W] = (i < m[c][k]) ? (r ^ 4'h1) : r;
    end
    @(negedge clk_i);
    lbl_valid_i = 1'b0;
  endtask

  task automatic run_window(int num, int den, int exp_start);
    int t0;
    thr_num_i = THR_W'(num);
    thr_den_i = THR_W'(den);
    @(negedge clk_i);
    while (!training_o) @(negedge clk_i);
    t0 = cyc;
    check("R2 window start cycle", t0, exp_start);
    for (int c = 0; c < N_CH; c++) begin
      while (!(training_o && train_ch_o == CH_W'(c))) @(negedge clk_i);
      check("R6 channel step cycle", cyc, t0 + c * (W + 1));
      for (int j = 0; j < N_CH; j++)
        check("R7 full width during training", int'(res_o[j*RES_W +: RES_W]), 8);
      drive_spikes(c);
    end
    while (!done_o) @(negedge clk_i);
    check("R8 done cycle", cyc, t0 + N_CH * (W + 1));
    check("R8 training low at done", int'(training_o), 0);
    @(negedge clk_i);
    check("R8 done single cycle", int'(done_o), 0);
    for (int c = 0; c < N_CH; c++)
      check("R3 R4 R5 chosen width", int'(res_o[c*RES_W +: RES_W]), calc(c, num, den));
  endtask

  initial begin
    rst_ni = 1'b0; period_i = P; window_i = W;
    thr_num_i = '0; thr_den_i = 8'd1;
    lbl_valid_i = 1'b0; lbl_ref_i = '0; lbl_red_i = '0;
    repeat (3) @(negedge clk_i);
    for (int c = 0; c < N_CH; c++)
      check("R1 reset width", int'(res_o[c*RES_W +: RES_W]), 8);
    check("R1 reset training", int'(training_o), 0);
    check("R1 reset done", int'(done_o), 0);
    rst_ni = 1'b1;

    // idle labels must be discarded (R9)
    noise(10);
    while (cyc < P - 1) @(negedge clk_i);
    check("R2 no window before period", int'(training_o), 0);

    // window 1, limit 10%
    s = '{20, 20, 20, 0};
    m = '{'{5, 3, 1, 0, 0}, '{0, 0, 0, 0, 0}, '{2, 2, 2, 2, 2}, '{0, 0, 0, 0, 0}};
    run_window(1, 10, P);
    check("R4 strict boundary ch2", int'(res_o[2*RES_W +: RES_W]), 8);
    check("R5 zero spikes ch3", int'(res_o[3*RES_W +: RES_W]), 8);

    noise(10);  // R9: ignored between windows

    // window 2, limit 25%, counters must start afresh
    s = '{20, 20, 20, 10};
    m = '{'{5, 3, 1, 0, 0}, '{20, 20, 20, 20, 20}, '{4, 4, 4, 4, 4}, '{3, 2, 2, 0, 0}};
    run_window(1, 4, 2 * P);
    check("R9 cleared counters ch0", int'(res_o[0*RES_W +: RES_W]), 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule